// File: doc/BRIEF.md
# Dual-Pipe Micro-Op Issue Scheduler

This block is the shared reservation buffer in front of a two-pipe vector and floating-point execution cluster. Renamed micro-ops arrive from dispatch, up to two per cycle, each with an operation class, two source tags with their ready bits, and a destination tag. The block holds them until every source is ready, then hands each one to an execution pipe.

Every cycle the scheduler compares the stored source tags against the result tags broadcast by the execution pipes and marks matching sources ready. It then picks at most one ready micro-op for each pipe, oldest first. Each class is bound to the pipe that owns its execution unit. Simple logical, move and shuffle micro-ops may go to either pipe. Each pipe has a stall input that holds its issue slot empty while the chosen micro-op stays in the buffer.

Top module: `issue_sched_dual`

## Requirements
- R1: The buffer holds 18 entries. `disp_ready` is high exactly when the number of free entries is at least the number of asserted `disp_valid` bits. Both offered micro-ops are written when it is high, and none is written when it is low. An entry released in a cycle is not counted as free in that cycle.
- R2: When both dispatch slots are accepted in one cycle, slot 0 counts as older than slot 1.
- R3: Class codes and their pipe binding: 0 float add, 1 vector integer multiply, 2 vector ALU A and 7 may only issue on pipe 0. 3 float multiply, 4 store/convert and 5 vector ALU B may only issue on pipe 1.
- R4: Class 6 (logical/move/shuffle) may issue on either pipe, and on only one pipe in a cycle. The oldest ready class-6 entry goes to pipe 0 when pipe 0 is not stalled. Otherwise pipe 1 may take it, and a younger eligible entry may take pipe 1 in the same cycle that an older one takes pipe 0.
- R5: Among the entries a pipe could take, that pipe issues the oldest.
- R6: A broadcast on either result lane that matches a stored source tag in clock cycle N makes the entry issuable in cycle N+1, and not earlier. A broadcast in the same cycle as the entry's dispatch is also captured. A non-matching tag wakes nothing.
- R7: While `pX_stall` is high, `pX_valid` is low and the micro-op that would have issued remains buffered. It issues after the stall drops.
- R8: After reset no entry is valid, both issue ports are idle and `disp_ready` is high.
- R9: An issued micro-op leaves the buffer at the end of its issue cycle and never issues again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 2 | Dispatch slot valid bits |
| disp_cls | input | 2x3 | Class code per slot |
| disp_src_tag | input | 2x2x6 | Source tags per slot |
| disp_src_rdy | input | 2x2 | Source ready bits per slot |
| disp_dst | input | 2x6 | Destination tag per slot |
| disp_ready | output | 1 | Whole offered group accepted this cycle |
| bc_valid | input | 2 | Result broadcast lane valid bits |
| bc_tag | input | 2x6 | Result tags being broadcast |
| p0_stall | input | 1 | Pipe 0 cannot accept a micro-op |
| p0_valid | output | 1 | Pipe 0 issue this cycle |
| p0_cls | output | 3 | Class of the pipe 0 micro-op |
| p0_dst | output | 6 | Destination tag of the pipe 0 micro-op |
| p1_stall | input | 1 | Pipe 1 cannot accept a micro-op |
| p1_valid | output | 1 | Pipe 1 issue this cycle |
| p1_cls | output | 3 | Class of the pipe 1 micro-op |
| p1_dst | output | 6 | Destination tag of the pipe 1 micro-op |

## Verification
The hardest states to reach are a nearly full buffer, where a group of two must be refused while a single micro-op would fit, and two ready class-6 entries competing with pipe-bound ones for both pipes. The stimulus parks micro-ops behind a source tag that is never broadcast until the buffer holds 17 and then 18 entries. It probes the ready signal with one and with two offers, then releases everything with one broadcast and expects the entries back strictly in age order. Stalls on one pipe or both pile up ready entries, so each arbitration case between dual-eligible and pipe-bound entries is set up and then released in a single cycle.

// File: rtl/sched_pkg.sv
// Shared constants for the dual-pipe issue scheduler.
// Assumes a 3-bit operation class. Codes 0,1,2,7 are pipe 0 only,
// 3,4,5 are pipe 1 only, and 6 may issue on either pipe.
package sched_pkg;

    localparam int CLS_W = 3;

    localparam logic [CLS_W-1:0] CLS_FADD  = 3'd0;
    localparam logic [CLS_W-1:0] CLS_VIMUL = 3'd1;
    localparam logic [CLS_W-1:0] CLS_VALUA = 3'd2;
    localparam logic [CLS_W-1:0] CLS_FMUL  = 3'd3;
    localparam logic [CLS_W-1:0] CLS_STCV  = 3'd4;
    localparam logic [CLS_W-1:0] CLS_VALUB = 3'd5;
    localparam logic [CLS_W-1:0] CLS_LMS   = 3'd6;

    // Pipes that may execute a class: bit 0 = pipe 0, bit 1 = pipe 1.
    function automatic logic [1:0] pipe_mask(input logic [CLS_W-1:0] c);
        case (c)
            CLS_FMUL, CLS_STCV, CLS_VALUB: pipe_mask = 2'b10;
            CLS_LMS:                       pipe_mask = 2'b11;
            default:                       pipe_mask = 2'b01;
        endcase
    endfunction

endpackage

// File: rtl/sched_entry_array.sv
// Entry storage for the scheduler: valid bit, class, source tags with
// ready bits and destination tag per entry, plus tag-match wakeup.
// Assumes the allocation one-hots from the top only point at free entries
// and never select the same entry for both slots.
module sched_entry_array
    import sched_pkg::*;
#(
    parameter int ENTRIES = 18,
    parameter int TAG_W   = 6,
    parameter int NSRC    = 2,
    parameter int BC_N    = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [1:0][ENTRIES-1:0]                alloc_oh,
    input  logic [1:0][CLS_W-1:0]                  in_cls,
    input  logic [1:0][NSRC-1:0][TAG_W-1:0]        in_tag,
    input  logic [1:0][NSRC-1:0]                   in_rdy,
    input  logic [1:0][TAG_W-1:0]                  in_dst,
    input  logic [ENTRIES-1:0]                     release_mask,
    input  logic [BC_N-1:0]                        bc_valid,
    input  logic [BC_N-1:0][TAG_W-1:0]             bc_tag,
    output logic [ENTRIES-1:0]                     ent_valid,
    output logic [ENTRIES-1:0]                     ent_ready,
    output logic [ENTRIES-1:0][CLS_W-1:0]          ent_cls,
    output logic [ENTRIES-1:0][TAG_W-1:0]          ent_dst
);

    logic [ENTRIES-1:0]                  valid_q;
    logic [ENTRIES-1:0][NSRC-1:0]        rdy_q;
    logic [ENTRIES-1:0][NSRC-1:0][TAG_W-1:0] tag_q;
    logic [ENTRIES-1:0][CLS_W-1:0]       cls_q;
    logic [ENTRIES-1:0][TAG_W-1:0]       dst_q;
    logic [ENTRIES-1:0][NSRC-1:0]        wake;
    logic [1:0][NSRC-1:0]                in_wake;

    // Compare every stored and incoming source tag against the broadcast lanes.
    always_comb begin
        wake    = '0;
        in_wake = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            for (int s = 0; s < NSRC; s++) begin
                for (int b = 0; b < BC_N; b++) begin
                    if (bc_valid[b] && bc_tag[b] == tag_q[e][s]) wake[e][s] = 1'b1;
                end
            end
        end
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < NSRC; s++) begin
                for (int b = 0; b < BC_N; b++) begin
                    if (bc_valid[b] && bc_tag[b] == in_tag[d][s]) in_wake[d][s] = 1'b1;
                end
            end
        end
    end

    // Load new micro-ops, retire issued ones and accumulate source readiness.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rdy_q   <= '0;
            tag_q   <= '0;
            cls_q   <= '0;
            dst_q   <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (alloc_oh[0][e]) begin
                    valid_q[e] <= 1'b1;
                    cls_q[e]   <= in_cls[0];
                    tag_q[e]   <= in_tag[0];
                    dst_q[e]   <= in_dst[0];
                    rdy_q[e]   <= in_rdy[0] | in_wake[0];
                end else if (alloc_oh[1][e]) begin
                    valid_q[e] <= 1'b1;
                    cls_q[e]   <= in_cls[1];
                    tag_q[e]   <= in_tag[1];
                    dst_q[e]   <= in_dst[1];
                    rdy_q[e]   <= in_rdy[1] | in_wake[1];
                end else begin
                    if (release_mask[e]) valid_q[e] <= 1'b0;
                    rdy_q[e] <= rdy_q[e] | wake[e];
                end
            end
        end
    end

    // Present entry state to the pickers.
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            ent_ready[e] = &rdy_q[e];
        end
    end

    assign ent_valid = valid_q;
    assign ent_cls   = cls_q;
    assign ent_dst   = dst_q;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
        // R1: allocation only ever targets an empty entry.
        a_r1_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_oh[0][e] || alloc_oh[1][e]) |-> !valid_q[e]);
        // R9: an issued entry is gone in the next cycle.
        a_r9_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (release_mask[e] && !alloc_oh[0][e] && !alloc_oh[1][e]) |=> !valid_q[e]);
    end

endmodule

// File: rtl/sched_age_matrix.sv
// Relative age of every pair of entries. older[j][i] is set when entry j
// was written before entry i. Assumes slot 0 is older than slot 1 when
// both are allocated in one cycle. Bits of empty entries are ignored by
// the pickers and are rewritten when those entries are reused.
module sched_age_matrix #(
    parameter int ENTRIES = 18
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [1:0][ENTRIES-1:0]         alloc_oh,
    output logic [ENTRIES-1:0][ENTRIES-1:0] older
);

    logic [ENTRIES-1:0][ENTRIES-1:0] older_q;
    logic [ENTRIES-1:0]              alloc_any;

    assign alloc_any = alloc_oh[0] | alloc_oh[1];

    // A new entry is younger than everything present; slot 0 beats slot 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_q <= '0;
        end else begin
            for (int j = 0; j < ENTRIES; j++) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (i == j) begin
                        older_q[j][i] <= 1'b0;
                    end else if (alloc_any[j]) begin
                        older_q[j][i] <= alloc_oh[0][j] && alloc_oh[1][i];
                    end else if (alloc_any[i]) begin
                        older_q[j][i] <= 1'b1;
                    end
                end
            end
        end
    end

    assign older = older_q;

endmodule

// File: rtl/sched_oldest_pick.sv
// Grants the oldest requesting entry using the age matrix. Assumes the
// matrix is a strict order over the requesters, so at most one is granted.
module sched_oldest_pick #(
    parameter int ENTRIES = 18
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ENTRIES-1:0]              req,
    input  logic [ENTRIES-1:0][ENTRIES-1:0] older,
    output logic [ENTRIES-1:0]              grant,
    output logic                            any
);

    // A requester wins when no other requester is older than it.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < ENTRIES; j++) begin
                blocked = blocked | (req[j] & older[j][i]);
            end
            grant[i] = req[i] & ~blocked;
        end
    end

    assign any = |grant;

    // R5: one winner at most, and a winner whenever someone asks.
    a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r5_grant_when_req: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> any);

endmodule

// File: rtl/issue_sched_dual.sv
// Dual-pipe micro-op issue scheduler. Accepts up to two micro-ops per
// cycle into an 18-entry buffer, wakes sources on broadcast tags and
// issues the oldest ready micro-op per pipe, honouring class-to-pipe
// binding. Assumes dispatch holds its offer when disp_ready is low and
// that a pipe's stall is known early in the cycle.
module issue_sched_dual
    import sched_pkg::*;
#(
    parameter int ENTRIES = 18,
    parameter int TAG_W   = 6,
    parameter int NSRC    = 2,
    parameter int BC_N    = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [1:0]                      disp_valid,
    input  logic [1:0][CLS_W-1:0]           disp_cls,
    input  logic [1:0][NSRC-1:0][TAG_W-1:0] disp_src_tag,
    input  logic [1:0][NSRC-1:0]            disp_src_rdy,
    input  logic [1:0][TAG_W-1:0]           disp_dst,
    output logic                            disp_ready,
    input  logic [BC_N-1:0]                 bc_valid,
    input  logic [BC_N-1:0][TAG_W-1:0]      bc_tag,
    input  logic                            p0_stall,
    output logic                            p0_valid,
    output logic [CLS_W-1:0]                p0_cls,
    output logic [TAG_W-1:0]                p0_dst,
    input  logic                            p1_stall,
    output logic                            p1_valid,
    output logic [CLS_W-1:0]                p1_cls,
    output logic [TAG_W-1:0]                p1_dst
);

    localparam int CNT_W = $clog2(ENTRIES + 1);

    logic [ENTRIES-1:0]              ent_valid, ent_ready;
    logic [ENTRIES-1:0][CLS_W-1:0]   ent_cls;
    logic [ENTRIES-1:0][TAG_W-1:0]   ent_dst;
    logic [ENTRIES-1:0][ENTRIES-1:0] older;
    logic [ENTRIES-1:0]              on_p0, on_p1;
    logic [ENTRIES-1:0]              req0, req1, grant0, grant1;
    logic                            any0, any1;
    logic [ENTRIES-1:0]              first0, first1;
    logic [CNT_W-1:0]                free_cnt;
    logic [1:0]                      need;
    logic [1:0][ENTRIES-1:0]         alloc_oh;

    // Find the two lowest free entries and count all free ones.
    always_comb begin
        logic found0, found1;
        first0   = '0;
        first1   = '0;
        found0   = 1'b0;
        found1   = 1'b0;
        free_cnt = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (!ent_valid[e]) begin
                free_cnt = free_cnt + {{(CNT_W-1){1'b0}}, 1'b1};
                if (!found0) begin
                    first0[e] = 1'b1;
                    found0    = 1'b1;
                end else if (!found1) begin
                    first1[e] = 1'b1;
                    found1    = 1'b1;
                end
            end
        end
    end

    // Accept the offered group only when it fits entirely.
    always_comb begin
        need       = {1'b0, disp_valid[0]} + {1'b0, disp_valid[1]};
        disp_ready = free_cnt >= {{(CNT_W-2){1'b0}}, need};
        alloc_oh[0] = (disp_ready && disp_valid[0]) ? first0 : '0;
        alloc_oh[1] = (disp_ready && disp_valid[1]) ? (disp_valid[0] ? first1 : first0) : '0;
    end

    sched_entry_array #(
        .ENTRIES(ENTRIES), .TAG_W(TAG_W), .NSRC(NSRC), .BC_N(BC_N)
    ) u_entries (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_oh    (alloc_oh),
        .in_cls      (disp_cls),
        .in_tag      (disp_src_tag),
        .in_rdy      (disp_src_rdy),
        .in_dst      (disp_dst),
        .release_mask(grant0 | grant1),
        .bc_valid    (bc_valid),
        .bc_tag      (bc_tag),
        .ent_valid   (ent_valid),
        .ent_ready   (ent_ready),
        .ent_cls     (ent_cls),
        .ent_dst     (ent_dst)
    );

    sched_age_matrix #(.ENTRIES(ENTRIES)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc_oh(alloc_oh),
        .older   (older)
    );

    // Decode which pipes each stored class may use.
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            logic [1:0] m;
            m        = pipe_mask(ent_cls[e]);
            on_p0[e] = m[0];
            on_p1[e] = m[1];
        end
    end

    // Pipe 0 picks first; pipe 1 skips whatever pipe 0 took.
    assign req0 = ent_valid & ent_ready & on_p0 & {ENTRIES{!p0_stall}};
    assign req1 = ent_valid & ent_ready & on_p1 & ~grant0 & {ENTRIES{!p1_stall}};

    sched_oldest_pick #(.ENTRIES(ENTRIES)) u_pick0 (
        .clk(clk), .rst_n(rst_n), .req(req0), .older(older), .grant(grant0), .any(any0)
    );

    sched_oldest_pick #(.ENTRIES(ENTRIES)) u_pick1 (
        .clk(clk), .rst_n(rst_n), .req(req1), .older(older), .grant(grant1), .any(any1)
    );

    // Drive the issue ports from the one-hot grants.
    always_comb begin
        p0_cls = '0;
        p0_dst = '0;
        p1_cls = '0;
        p1_dst = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (grant0[e]) begin
                p0_cls = p0_cls | ent_cls[e];
                p0_dst = p0_dst | ent_dst[e];
            end
            if (grant1[e]) begin
                p1_cls = p1_cls | ent_cls[e];
                p1_dst = p1_dst | ent_dst[e];
            end
        end
    end

    assign p0_valid = any0;
    assign p1_valid = any1;

    // R3: each port carries only classes its pipe can execute.
    a_r3_pipe0_class: assert property (@(posedge clk) disable iff (!rst_n)
        p0_valid |-> (p0_cls != CLS_FMUL && p0_cls != CLS_STCV && p0_cls != CLS_VALUB));
    a_r3_pipe1_class: assert property (@(posedge clk) disable iff (!rst_n)
        p1_valid |-> (p1_cls == CLS_FMUL || p1_cls == CLS_STCV ||
                      p1_cls == CLS_VALUB || p1_cls == CLS_LMS));
    // R4: no entry issues on both pipes at once.
    a_r4_single_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        (grant0 & grant1) == '0);
    // R7: a stalled pipe stays idle.
    a_r7_stall0_idle: assert property (@(posedge clk) disable iff (!rst_n)
        p0_stall |-> !p0_valid);
    a_r7_stall1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        p1_stall |-> !p1_valid);
    // R1: an accepted group never exceeds the free space.
    a_r1_fits: assert property (@(posedge clk) disable iff (!rst_n)
        disp_ready |-> ($countones(alloc_oh) == $countones(disp_valid)));

endmodule

// File: tb/issue_sched_dual_tb.sv
module issue_sched_dual_tb;
    import sched_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [1:0]           disp_valid = '0;
    logic [1:0][2:0]      disp_cls = '0;
    logic [1:0][1:0][5:0] disp_src_tag = '0;
    logic [1:0][1:0]      disp_src_rdy = '0;
    logic [1:0][5:0]      disp_dst = '0;
    logic                 disp_ready;
    logic [1:0]           bc_valid = '0;
    logic [1:0][5:0]      bc_tag = '0;
    logic                 p0_stall = 1'b0, p1_stall = 1'b0;
    logic                 p0_valid, p1_valid;
    logic [2:0]           p0_cls, p1_cls;
    logic [5:0]           p0_dst, p1_dst;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct {
        logic [2:0] cls;
        logic [5:0] dst;
        string      req;
    } exp_t;
    exp_t q0[$];
    exp_t q1[$];

    always #2 clk = ~clk;

    issue_sched_dual u_dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_cls(disp_cls), .disp_src_tag(disp_src_tag),
        .disp_src_rdy(disp_src_rdy), .disp_dst(disp_dst), .disp_ready(disp_ready),
        .bc_valid(bc_valid), .bc_tag(bc_tag),
        .p0_stall(p0_stall), .p0_valid(p0_valid), .p0_cls(p0_cls), .p0_dst(p0_dst),
        .p1_stall(p1_stall), .p1_valid(p1_valid), .p1_cls(p1_cls), .p1_dst(p1_dst)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_issue(input int pipe, input logic [2:0] c, input logic [5:0] d,
                                input string req);
        exp_t e;
        e.cls = c; e.dst = d; e.req = req;
        if (pipe == 0) q0.push_back(e); else q1.push_back(e);
    endtask

    task automatic put(input int s, input logic [2:0] c, input logic [5:0] d,
                       input logic [5:0] t, input logic r);
        disp_valid[s]      = 1'b1;
        disp_cls[s]        = c;
        disp_dst[s]        = d;
        disp_src_tag[s][0] = t;
        disp_src_rdy[s][0] = r;
        disp_src_tag[s][1] = 6'd0;
        disp_src_rdy[s][1] = 1'b1;
    endtask

    // One clock edge; inputs change 1 ns after it, outputs are read at negedge.
    task automatic step;
        @(posedge clk);
        #1;
        disp_valid = '0;
        bc_valid   = '0;
    endtask

    task automatic mon_pipe(input int pipe, input logic v, input logic [2:0] c,
                            input logic [5:0] d);
        exp_t e;
        if (!v) return;
        n_checks++;
        if ((pipe == 0 && q0.size() == 0) || (pipe == 1 && q1.size() == 0)) begin
            n_fail++;
            $display("FAIL R9 pipe%0d unexpected issue actual dst=%0d expected none", pipe, d);
            return;
        end
        e = (pipe == 0) ? q0.pop_front() : q1.pop_front();
        if (c !== e.cls || d !== e.dst) begin
            n_fail++;
            $display("FAIL %s pipe%0d actual cls=%0d dst=%0d expected cls=%0d dst=%0d",
                     e.req, pipe, c, d, e.cls, e.dst);
        end
    endtask

    // Monitor: compare every issue against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            mon_pipe(0, p0_valid, p0_cls, p0_dst);
            mon_pipe(1, p1_valid, p1_cls, p1_dst);
        end
    end

    task automatic finish_run;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) step();
        @(negedge clk);
        check("R8 p0_valid", {7'd0, p0_valid}, 8'd0);
        check("R8 p1_valid", {7'd0, p1_valid}, 8'd0);
        check("R8 disp_ready", {7'd0, disp_ready}, 8'd1);
        step();
        rst_n = 1'b1;
        step();

        // R3: classes go to their own pipes.
        expect_issue(0, CLS_FADD, 6'd1, "R3");
        expect_issue(1, CLS_STCV, 6'd2, "R3");
        put(0, CLS_FADD, 6'd1, 6'd0, 1'b1);
        put(1, CLS_STCV, 6'd2, 6'd0, 1'b1);
        step();
        expect_issue(1, CLS_VALUB, 6'd3, "R3");
        expect_issue(0, CLS_VIMUL, 6'd4, "R3");
        put(0, CLS_VALUB, 6'd3, 6'd0, 1'b1);
        put(1, CLS_VIMUL, 6'd4, 6'd0, 1'b1);
        step();
        expect_issue(1, CLS_FMUL, 6'd5, "R3");
        expect_issue(0, CLS_VALUA, 6'd6, "R3");
        put(0, CLS_FMUL, 6'd5, 6'd0, 1'b1);
        put(1, CLS_VALUA, 6'd6, 6'd0, 1'b1);
        step();
        expect_issue(0, 3'd7, 6'd7, "R3");
        put(1, 3'd7, 6'd7, 6'd0, 1'b1);
        repeat (3) step();
        @(negedge clk);
        check("R9 idle p0", {7'd0, p0_valid}, 8'd0);
        check("R9 idle p1", {7'd0, p1_valid}, 8'd0);

        // R7, R5, R2: stall pipe 0 and pile up three adds.
        step();
        p0_stall = 1'b1;
        put(0, CLS_FADD, 6'd11, 6'd0, 1'b1);
        put(1, CLS_FADD, 6'd12, 6'd0, 1'b1);
        step();
        put(0, CLS_FADD, 6'd13, 6'd0, 1'b1);
        step();
        step();
        @(negedge clk);
        check("R7 stalled p0 idle", {7'd0, p0_valid}, 8'd0);
        expect_issue(0, CLS_FADD, 6'd11, "R2 R5 R7");
        expect_issue(0, CLS_FADD, 6'd12, "R2 R5");
        expect_issue(0, CLS_FADD, 6'd13, "R5");
        step();
        p0_stall = 1'b0;
        repeat (5) step();

        // R4: two dual-eligible ops split across the pipes.
        expect_issue(0, CLS_LMS, 6'd14, "R4");
        expect_issue(1, CLS_LMS, 6'd15, "R4");
        put(0, CLS_LMS, 6'd14, 6'd0, 1'b1);
        put(1, CLS_LMS, 6'd15, 6'd0, 1'b1);
        step();
        step();
        // R4: pipe 1 stalled, both go to pipe 0 in order.
        p1_stall = 1'b1;
        expect_issue(0, CLS_LMS, 6'd16, "R4");
        expect_issue(0, CLS_LMS, 6'd17, "R4");
        put(0, CLS_LMS, 6'd16, 6'd0, 1'b1);
        put(1, CLS_LMS, 6'd17, 6'd0, 1'b1);
        repeat (3) step();
        p1_stall = 1'b0;
        // R4: pipe 0 stalled, a dual op takes pipe 1.
        p0_stall = 1'b1;
        expect_issue(1, CLS_LMS, 6'd18, "R4");
        put(0, CLS_LMS, 6'd18, 6'd0, 1'b1);
        repeat (3) step();
        p0_stall = 1'b0;
        step();
        // R4: older dual op vs younger pipe-1 op, released together.
        p0_stall = 1'b1;
        p1_stall = 1'b1;
        put(0, CLS_LMS, 6'd19, 6'd0, 1'b1);
        step();
        put(0, CLS_FMUL, 6'd20, 6'd0, 1'b1);
        step();
        @(negedge clk);
        check("R7 both stalled p0", {7'd0, p0_valid}, 8'd0);
        check("R7 both stalled p1", {7'd0, p1_valid}, 8'd0);
        expect_issue(0, CLS_LMS, 6'd19, "R4");
        expect_issue(1, CLS_FMUL, 6'd20, "R4");
        step();
        p0_stall = 1'b0;
        p1_stall = 1'b0;
        step();
        // R4: older pipe-1 op keeps pipe 1, younger dual op takes pipe 0.
        p0_stall = 1'b1;
        p1_stall = 1'b1;
        put(0, CLS_FMUL, 6'd21, 6'd0, 1'b1);
        put(1, CLS_LMS, 6'd22, 6'd0, 1'b1);
        step();
        expect_issue(0, CLS_LMS, 6'd22, "R4");
        expect_issue(1, CLS_FMUL, 6'd21, "R4");
        p0_stall = 1'b0;
        p1_stall = 1'b0;
        repeat (2) step();

        // R6: wakeup timing on lane 1.
        put(0, CLS_FADD, 6'd24, 6'd40, 1'b0);
        step();
        step();
        @(negedge clk);
        check("R6 waiting source", {7'd0, p0_valid}, 8'd0);
        step();
        bc_valid[1] = 1'b1;
        bc_tag[1]   = 6'd40;
        @(negedge clk);
        check("R6 not in broadcast cycle", {7'd0, p0_valid}, 8'd0);
        expect_issue(0, CLS_FADD, 6'd24, "R6 next cycle");
        step();
        step();
        // R6: broadcast in the dispatch cycle is captured.
        expect_issue(0, CLS_FADD, 6'd25, "R6 dispatch capture");
        put(0, CLS_FADD, 6'd25, 6'd41, 1'b0);
        bc_valid[0] = 1'b1;
        bc_tag[0]   = 6'd41;
        step();
        step();
        // R6: a different tag wakes nothing.
        put(0, CLS_FADD, 6'd26, 6'd42, 1'b0);
        step();
        bc_valid[0] = 1'b1;
        bc_tag[0]   = 6'd43;
        step();
        step();
        @(negedge clk);
        check("R6 wrong tag", {7'd0, p0_valid}, 8'd0);
        expect_issue(0, CLS_FADD, 6'd26, "R6");
        step();
        bc_valid[0] = 1'b1;
        bc_tag[0]   = 6'd42;
        repeat (3) step();

        // R1: fill to 17 behind tag 50, probe refusal, fill to 18.
        for (int k = 0; k < 8; k++) begin
            put(0, CLS_FADD, 6'(32 + 2 * k), 6'd50, 1'b0);
            put(1, CLS_FADD, 6'(33 + 2 * k), 6'd50, 1'b0);
            step();
        end
        put(0, CLS_FADD, 6'd48, 6'd50, 1'b0);
        step();
        put(0, CLS_FADD, 6'd60, 6'd50, 1'b0);
        put(1, CLS_FADD, 6'd61, 6'd50, 1'b0);
        @(negedge clk);
        check("R1 two offered one free", {7'd0, disp_ready}, 8'd0);
        #1;
        disp_valid = 2'b00;
        put(0, CLS_FADD, 6'd49, 6'd50, 1'b0);
        #0.5;
        check("R1 one offered one free", {7'd0, disp_ready}, 8'd1);
        step();
        put(1, CLS_FADD, 6'd62, 6'd50, 1'b0);
        @(negedge clk);
        check("R1 full", {7'd0, disp_ready}, 8'd0);
        step();
        for (int k = 32; k < 50; k++) expect_issue(0, CLS_FADD, 6'(k), "R1 R5 drain");
        bc_valid[1] = 1'b1;
        bc_tag[1]   = 6'd50;
        repeat (22) step();
        @(negedge clk);
        check("R9 drained p0", {7'd0, p0_valid}, 8'd0);
        check("R1 ready after drain", {7'd0, disp_ready}, 8'd1);

        check("scoreboard q0 empty", 8'(q0.size()), 8'd0);
        check("scoreboard q1 empty", 8'(q1.size()), 8'd0);
        finish_run();
    end

endmodule